// File: doc/BRIEF.md
# 4KB-Boundary DMA Burst Splitter

This block sits in front of a PCI Express style requester and turns one DMA transfer request into a series of write bursts. A request gives a start byte address, a length in bytes and a per-transfer burst limit in dwords. The block emits one burst descriptor at a time: byte address, dword count, and first and last flags. Each descriptor is offered on a valid/ready handshake. The datapath is 32 bits wide, so all arithmetic is done in dword units. Typical transfers run from 64 to 1536 bytes, and the nominal burst is 8 dwords (32 bytes).

Each burst takes the smallest of three values: the remaining length, the burst limit, and the room left before the next 4KB page boundary. The burst limit is the requested value capped at the maximum payload, which is 256 bytes by default. A burst that would run past a boundary is cut off at the last dword below it, and the following burst starts exactly on the boundary.

A request that is not dword aligned, that is empty, or that asks for a zero burst limit is refused with a one-cycle error pulse, and no bursts are issued for it. After the final burst is accepted, the block raises a one-cycle completion pulse and returns to idle.

Top module: `burst_splitter`

## Requirements
- R1: After reset, burst_valid, done and req_err are 0 and req_ready is 1.
- R2: Bursts follow each other with no gap or overlap. Each burst's byte address equals the previous burst's address plus 4 times its dword count, and each burst's dword count is the minimum of the remaining dwords, the effective limit, and the dwords left before the next 4KB boundary (1024 minus address bits 11:2).
- R3: No burst covers bytes on both sides of an address that is a multiple of 0x1000. A burst cut at a boundary is followed by one that starts on it.
- R4: The effective limit is cfg_burst_dw, capped at MAX_PAYLOAD/4 dwords (64 by default). A cfg_burst_dw value above the cap produces bursts of the cap size.
- R5: burst_first is 1 on the first burst of a transfer only, and burst_last is 1 on the final burst only.
- R6: The dword counts of a transfer's bursts add up to req_len/4.
- R7: A request is refused if req_addr bits 1:0 are nonzero, req_len bits 1:0 are nonzero, req_len is 0, or cfg_burst_dw is 0. A refused request gives req_err = 1 in the cycle after it is presented, issues no bursts, and leaves req_ready at 1.
- R8: done is 1 for exactly one cycle, the cycle after the handshake of the burst with burst_last = 1, and is 0 at all other times.
- R9: While burst_valid is 1 and burst_ready is 0, burst_addr, burst_dw, burst_first and burst_last hold their values into the next cycle.
- R10: req_ready is 0 from the cycle after a request is accepted until done. A req_valid presented while req_ready is 0 is ignored and starts no bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| cfg_burst_dw | input | CFG_W | Requested burst limit in dwords |
| req_err | output | 1 | Pulse: request refused |
| burst_valid | output | 1 | Burst descriptor offered |
| burst_ready | input | 1 | Requester takes the descriptor |
| burst_addr | output | ADDR_W | Burst byte address |
| burst_dw | output | clog2(MAX_PAYLOAD/4+1) | Burst length in dwords |
| burst_first | output | 1 | First burst of the transfer |
| burst_last | output | 1 | Final burst of the transfer |
| done | output | 1 | Pulse: transfer complete |

## Verification
The hardest case to reach from the ports is a clip of a single dword: a start address 4 bytes below a page boundary, together with a limit capped at the maximum payload, while the requester stalls the handshake. The bench reaches it by choosing start addresses just below 0x1000 multiples and limits above the cap. A scoreboard predicts every burst from the arithmetic in the requirements, and burst_ready is throttled at random. To show that requests arriving during a transfer are ignored, req_valid is held with unrelated values while the block is busy. Any extra burst then appears as an unexpected item at the scoreboard.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bsplit_limit.sv
module bsplit_limit #(
  parameter int CFG_W  = 8,
  parameter int BDW    = 7,
  parameter int MAX_DW = 64
) (
  input  logic [CFG_W-1:0] cfg_dw,
  output logic [BDW-1:0]   lim_dw
);

  localparam int CFG_MAX = (1 << CFG_W) - 1;

  generate
    if (CFG_MAX > MAX_DW) begin : g_clamp
      always_comb begin
        if (cfg_dw > CFG_W'(MAX_DW)) lim_dw = BDW'(MAX_DW);
        else                         lim_dw = BDW'(cfg_dw);
      end
    end else begin : g_pass
      assign lim_dw = BDW'(cfg_dw);
    end
  endgenerate

endmodule

// File: rtl/bsplit_len_calc.sv
module bsplit_len_calc #(
  parameter int PB  = 10,
  parameter int RW  = 14,
  parameter int BDW = 7,
  parameter int CW  = 14
) (
  input  logic [PB-1:0]  addr_low,
  input  logic [RW-1:0]  rem_dw,
  input  logic [BDW-1:0] lim_dw,
  output logic [CW-1:0]  len_dw
);

  localparam int PAGE_DW = 1 << PB;

  logic [CW-1:0] room;
  logic [CW-1:0] rem_e;
  logic [CW-1:0] lim_e;
  logic [CW-1:0] cap;

  always_comb begin
    room   = CW'(PAGE_DW) - CW'(addr_low);
    rem_e  = CW'(rem_dw);
    lim_e  = CW'(lim_dw);
    cap    = (rem_e < lim_e) ? rem_e : lim_e;
    len_dw = (cap < room) ? cap : room;
  end

endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq
  import bsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int PB     = 10,
  parameter int BDW    = 7,
  parameter int CW     = 14,
  localparam int AW    = ADDR_W - 2,
  localparam int RW    = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BDW-1:0]    lim_in,
  output logic              req_ready,
  output logic              req_err,
  output logic [PB-1:0]     calc_addr_low,
  output logic [RW-1:0]     calc_rem,
  output logic [BDW-1:0]    calc_lim,
  input  logic [CW-1:0]     calc_len,
  input  logic              burst_ready,
  output logic              burst_valid,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [BDW-1:0]    burst_dw,
  output logic              burst_first,
  output logic              burst_last,
  output logic              done
);

  localparam int PAGE_DW = 1 << PB;

  seq_state_e     state_q;
  logic [BDW-1:0] lim_q;
  logic [AW-1:0]  nxt_q;
  logic [RW-1:0]  rem_q;
  logic           ov_q;
  logic [AW-1:0]  oa_q;
  logic [BDW-1:0] od_q;
  logic           of_q;
  logic           ol_q;
  logic           done_q;
  logic           err_q;

  logic [AW-1:0]  calc_addr;
  logic           req_ok;
  logic           last_now;
  logic           busy;

  assign busy      = (state_q == SEQ_RUN);
  assign calc_addr = busy ? nxt_q : req_addr[ADDR_W-1:2];
  assign calc_rem  = busy ? rem_q : req_len[LEN_W-1:2];
  assign calc_lim  = busy ? lim_q : lim_in;
  assign calc_addr_low = calc_addr[PB-1:0];
  assign last_now  = (CW'(calc_rem) == calc_len);

  assign req_ok = (req_addr[1:0] == 2'b00) && (req_len[1:0] == 2'b00) &&
                  (req_len[LEN_W-1:2] != '0) && (lim_in != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      lim_q   <= '0;
      nxt_q   <= '0;
      rem_q   <= '0;
      ov_q    <= 1'b0;
      oa_q    <= '0;
      od_q    <= '0;
      of_q    <= 1'b0;
      ol_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (req_ok) begin
            state_q <= SEQ_RUN;
            lim_q   <= lim_in;
            ov_q    <= 1'b1;
            oa_q    <= calc_addr;
            od_q    <= BDW'(calc_len);
            of_q    <= 1'b1;
            ol_q    <= last_now;
            nxt_q   <= calc_addr + AW'(calc_len);
            rem_q   <= calc_rem - RW'(calc_len);
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (ov_q && burst_ready) begin
        if (ol_q) begin
          state_q <= SEQ_IDLE;
          ov_q    <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          ov_q  <= 1'b1;
          oa_q  <= calc_addr;
          od_q  <= BDW'(calc_len);
          of_q  <= 1'b0;
          ol_q  <= last_now;
          nxt_q <= calc_addr + AW'(calc_len);
          rem_q <= calc_rem - RW'(calc_len);
        end
      end
    end
  end

  assign req_ready   = !busy;
  assign req_err     = err_q;
  assign burst_valid = ov_q;
  assign burst_addr  = {oa_q, 2'b00};
  assign burst_dw    = od_q;
  assign burst_first = of_q;
  assign burst_last  = ol_q;
  assign done        = done_q;

  // R9: a stalled descriptor does not change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !burst_ready) |=> (ov_q && $stable({oa_q, od_q, of_q, ol_q})));

  // R3: the offered burst stays inside one 4KB page
  p_no_cross_r3: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> ((32'(oa_q[PB-1:0]) + 32'(od_q)) <= 32'(PAGE_DW)));

  // R4: burst length is nonzero and within the captured limit
  p_dw_limit_r4: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> ((od_q != '0) && (od_q <= lim_q)));

  // R8: completion follows the final handshake and lasts one cycle
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (ov_q && burst_ready && ol_q) |=> done_q);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: no new request is taken while a burst is outstanding
  p_ready_busy_r10: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> !req_ready);

  // R7: a refusal never comes with a burst
  p_err_no_burst_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !ov_q);

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import bsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CFG_W       = 8,
  parameter int MAX_PAYLOAD = 256,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [LEN_W-1:0]                     req_len,
  input  logic [CFG_W-1:0]                     cfg_burst_dw,
  output logic                                 req_err,
  output logic                                 burst_valid,
  input  logic                                 burst_ready,
  output logic [ADDR_W-1:0]                    burst_addr,
  output logic [$clog2(MAX_PAYLOAD/4+1)-1:0]   burst_dw,
  output logic                                 burst_first,
  output logic                                 burst_last,
  output logic                                 done
);

  localparam int RW     = LEN_W - 2;
  localparam int MAX_DW = MAX_PAYLOAD / 4;
  localparam int BDW    = $clog2(MAX_DW + 1);
  localparam int PB     = $clog2(PAGE_BYTES) - 2;
  localparam int CW     = imax(imax(RW, PB + 1), BDW);

  logic [BDW-1:0] lim_in;
  logic [PB-1:0]  calc_addr_low;
  logic [RW-1:0]  calc_rem;
  logic [BDW-1:0] calc_lim;
  logic [CW-1:0]  calc_len;

  bsplit_limit #(
    .CFG_W (CFG_W),
    .BDW   (BDW),
    .MAX_DW(MAX_DW)
  ) i_limit (
    .cfg_dw(cfg_burst_dw),
    .lim_dw(lim_in)
  );

  bsplit_len_calc #(
    .PB (PB),
    .RW (RW),
    .BDW(BDW),
    .CW (CW)
  ) i_len_calc (
    .addr_low(calc_addr_low),
    .rem_dw  (calc_rem),
    .lim_dw  (calc_lim),
    .len_dw  (calc_len)
  );

  bsplit_seq #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .PB    (PB),
    .BDW   (BDW),
    .CW    (CW)
  ) i_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .lim_in       (lim_in),
    .req_ready    (req_ready),
    .req_err      (req_err),
    .calc_addr_low(calc_addr_low),
    .calc_rem     (calc_rem),
    .calc_lim     (calc_lim),
    .calc_len     (calc_len),
    .burst_ready  (burst_ready),
    .burst_valid  (burst_valid),
    .burst_addr   (burst_addr),
    .burst_dw     (burst_dw),
    .burst_first  (burst_first),
    .burst_last   (burst_last),
    .done         (done)
  );

endmodule

// File: tb/test_burst_splitter.sv
`timescale 1ns/1ps
module test_burst_splitter;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int CFG_W  = 8;
  localparam int BDW    = 7;

  logic              clk;
  logic              rst;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [CFG_W-1:0]  cfg_burst_dw;
  logic              req_err;
  logic              burst_valid;
  logic              burst_ready;
  logic [ADDR_W-1:0] burst_addr;
  logic [BDW-1:0]    burst_dw;
  logic              burst_first;
  logic              burst_last;
  logic              done;

  typedef struct {
    longint addr;
    longint dw;
    bit     first;
    bit     last;
  } exp_t;

  exp_t   q[$];
  exp_t   e;
  int     checks;
  int     fails;
  bit     ready_rand;
  bit     want_done;
  bit     hold_pend;
  bit     finished;
  longint sum_dw;
  longint want_sum;
  logic [ADDR_W-1:0] h_addr;
  logic [BDW-1:0]    h_dw;
  logic              h_first;
  logic              h_last;

  burst_splitter i_burst_splitter (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .cfg_burst_dw(cfg_burst_dw),
    .req_err     (req_err),
    .burst_valid (burst_valid),
    .burst_ready (burst_ready),
    .burst_addr  (burst_addr),
    .burst_dw    (burst_dw),
    .burst_first (burst_first),
    .burst_last  (burst_last),
    .done        (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check(burst_valid && burst_addr == h_addr && burst_dw == h_dw &&
              burst_first == h_first && burst_last == h_last,
              "R9", "stalled descriptor changed", longint'(burst_addr), longint'(h_addr));
        hold_pend = 1'b0;
      end
      if (want_done) begin
        check(done == 1'b1, "R8", "done after last", longint'(done), 1);
        want_done = 1'b0;
      end else if (done) begin
        check(1'b0, "R8", "unexpected done", 1, 0);
      end
      burst_ready = ready_rand ? 1'($urandom % 2) : 1'b1;
      if (burst_valid && burst_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected burst", longint'(burst_addr), 0);
        end else begin
          e = q.pop_front();
          check(longint'(burst_addr) == e.addr, "R2", "burst address",
                longint'(burst_addr), e.addr);
          check(longint'(burst_dw) == e.dw, "R2 R4", "burst dwords",
                longint'(burst_dw), e.dw);
          check(burst_first == e.first && burst_last == e.last, "R5", "first/last flags",
                {burst_first, burst_last}, {e.first, e.last});
          check((longint'(burst_addr) % 4096) + longint'(burst_dw) * 4 <= 4096, "R3",
                "page crossing end", (longint'(burst_addr) % 4096) + longint'(burst_dw) * 4, 4096);
          sum_dw += longint'(burst_dw);
          if (e.last) begin
            want_done = 1'b1;
            check(sum_dw == want_sum, "R6", "dword total", sum_dw, want_sum);
            sum_dw = 0;
          end
        end
      end else if (burst_valid) begin
        hold_pend = 1'b1;
        h_addr  = burst_addr;
        h_dw    = burst_dw;
        h_first = burst_first;
        h_last  = burst_last;
      end
    end
  end

  task automatic send(input longint addr, input longint len, input int cfg, input bit junk);
    longint a;
    longint r;
    longint lim;
    longint room;
    longint n;
    bit     first;
    exp_t   x;
    a = addr;
    r = len;
    lim = (cfg > 64) ? 64 : cfg;
    first = 1'b1;
    while (r > 0) begin
      room = 4096 - (a % 4096);
      n = r;
      if (lim * 4 < n) n = lim * 4;
      if (room < n) n = room;
      x.addr = a; x.dw = n / 4; x.first = first; x.last = (n == r);
      q.push_back(x);
      a += n; r -= n; first = 1'b0;
    end
    want_sum = len / 4;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready while idle", longint'(req_ready), 1);
    req_addr = ADDR_W'(addr);
    req_len = LEN_W'(len);
    cfg_burst_dw = CFG_W'(cfg);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      req_valid = 1'b1;
      req_addr = 32'h0000_8000;
      req_len = 16'd64;
      cfg_burst_dw = 8'd1;
      repeat (2) @(negedge clk);
      check(req_ready == 1'b0, "R10", "ready while busy", longint'(req_ready), 0);
      req_valid = 1'b0;
    end
    while (q.size() != 0 || want_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic refuse(input longint addr, input longint len, input int cfg, input string what);
    @(negedge clk);
    req_addr = ADDR_W'(addr);
    req_len = LEN_W'(len);
    cfg_burst_dw = CFG_W'(cfg);
    req_valid = 1'b1;
    @(negedge clk);
    check(req_err == 1'b1, "R7", {what, " err pulse"}, longint'(req_err), 1);
    check(burst_valid == 1'b0 && req_ready == 1'b1, "R7", {what, " no burst"},
          {burst_valid, req_ready}, 1);
    req_valid = 1'b0;
    @(negedge clk);
    check(req_err == 1'b0, "R7", {what, " err cleared"}, longint'(req_err), 0);
    repeat (2) @(negedge clk);
    check(burst_valid == 1'b0, "R7", {what, " still no burst"}, longint'(burst_valid), 0);
  endtask

  initial begin
    checks = 0; fails = 0; ready_rand = 1'b0; want_done = 1'b0; hold_pend = 1'b0;
    finished = 1'b0; sum_dw = 0; want_sum = 0;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_len = '0; cfg_burst_dw = '0;
    burst_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(burst_valid == 1'b0 && done == 1'b0 && req_err == 1'b0 && req_ready == 1'b1,
          "R1", "reset state", {burst_valid, done, req_err, req_ready}, 4'b0001);

    send(64'hC41000, 64, 8, 1'b0);          // aligned page, nominal burst
    send(64'h0000_0FF4, 100, 8, 1'b0);      // 3-dword clip, restart on boundary
    send(64'h2000_0F00, 1536, 200, 1'b0);   // limit above payload cap
    send(64'h0000_0FFC, 1536, 64, 1'b0);    // single-dword clip
    send(64'h0000_0104, 200, 5, 1'b0);      // odd burst size
    ready_rand = 1'b1;
    send(64'hC41000, 1536, 8, 1'b1);        // throttled, busy requests ignored
    send(64'h0000_3FC0, 1536, 64, 1'b1);
    send(64'h0000_0FFC, 1536, 255, 1'b0);
    ready_rand = 1'b0;

    refuse(64'h0000_1002, 64, 8, "addr misaligned");
    refuse(64'h0000_1000, 66, 8, "len misaligned");
    refuse(64'h0000_1000, 0, 8, "zero length");
    refuse(64'h0000_1000, 64, 0, "zero limit");

    send(64'h0000_1000, 64, 8, 1'b0);       // normal after refusals

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule